// File: doc/BRIEF.md
# Dual Retriggerable Digital Pulse Stretcher

This block is a clocked, fully digital one-shot with several identical channels (two by default). Each channel watches three asynchronous inputs: a trigger that acts on its falling edge, a trigger that acts on its rising edge, and an active-low clear. A valid trigger raises the channel's pulse output for a programmed number of clock cycles. The complementary output always carries the inverse of the pulse.

Every pulse has two parts. A short hold phase comes first; its length is a parameter. A run phase follows, and its length is the width value sampled from the channel's width input when the trigger takes effect. A trigger during the hold phase is discarded, and this sets a minimum retrigger spacing. A trigger during the run phase restarts the run phase, so the pulse is stretched without a gap. Each input passes through a two-flop synchroniser and then edge detection, so a trigger changes the output on the third clock edge after the input changes.

Top module: `os_dual_oneshot`

## Requirements
- R1: A rising edge on `rise_trig_i[c]` while `fall_trig_i[c]` is low starts a pulse on channel c.
- R2: A falling edge on `fall_trig_i[c]` while `rise_trig_i[c]` is high starts a pulse on channel c.
- R3: A rising edge on `clr_n_i[c]` while `fall_trig_i[c]` is low and `rise_trig_i[c]` is high starts a pulse on channel c.
- R4: While `clr_n_i[c]` is low, the pulse of channel c is forced low within three clocks, and every trigger on that channel is ignored.
- R5: A high level on `fall_trig_i[c]` blocks triggering from `rise_trig_i[c]`, and a low level on `rise_trig_i[c]` blocks triggering from `fall_trig_i[c]`.
- R6: An input edge sampled at clock edge k sets `pulse_o[c]` high after edge k+2. The pulse stays high for exactly HOLD_CYC + W cycles, where W is `width_i[c*WIDTH_W +: WIDTH_W]` sampled when the trigger takes effect, and a value of 0 counts as 1.
- R7: A trigger that takes effect during the run phase restarts the run phase from zero, so the pulse stays high without a break.
- R8: A trigger that takes effect during the hold phase has no effect on the pulse length.
- R9: The channels are independent: activity on one channel never changes another channel's outputs.
- R10: `pulse_n_o` is always the bitwise inverse of `pulse_o`, including during and after reset, and after reset the pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fall_trig_i | input | N_CH | Falling-edge trigger, one bit per channel (asynchronous) |
| rise_trig_i | input | N_CH | Rising-edge trigger, one bit per channel (asynchronous) |
| clr_n_i | input | N_CH | Active-low clear per channel; its rising edge also triggers (asynchronous) |
| width_i | input | N_CH*WIDTH_W | Run-phase length per channel, channel c at bits c*WIDTH_W upward |
| pulse_o | output | N_CH | Pulse output per channel |
| pulse_n_o | output | N_CH | Inverse of pulse_o |

## Verification
The bench builds the block with two channels, a 4-bit width field and a hold phase of 2 cycles. This makes it possible to sweep every width value from 0 to 15 through both the rising-edge and the falling-edge trigger paths, and to check the latency and the exact length of each pulse. Because the pulses are short, the bench can also sweep the retrigger delay across the whole pulse. That covers the boundary between the hold phase and the run phase and the last run cycle, where a retrigger must still stretch the pulse. The clear trigger, the inhibit levels and forced clear mid-pulse are each checked while the other channel is watched for disturbance.

// File: rtl/os_pkg.sv
`timescale 1ns/1ps
// Shared types for the digital one-shot.
// Assumes: nothing; only declarations.
package os_pkg;
    // Phase of one channel's pulse.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_RUN  = 2'd2
    } phase_t;
endpackage

// File: rtl/os_sync_edge.sv
`timescale 1ns/1ps
// Two-flop synchroniser followed by one edge detector.
// DETECT_RISE selects whether edge_o flags a rising or a falling edge.
// Assumes: the input is asynchronous. Edge reports are held off for three
// clocks after reset so that the reset values of the flops cannot look like an edge.
module os_sync_edge #(
    parameter bit DETECT_RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic lvl_o,
    output logic edge_o
);
    localparam int ARM_STAGES = 3;

    logic                  s1_q, s2_q, prev_q;
    logic [ARM_STAGES-1:0] arm_q;

    // Resolve metastability in two flops and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= async_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Arm edge reporting once the pipeline holds real input values.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= '0;
        else        arm_q <= {arm_q[ARM_STAGES-2:0], 1'b1};
    end

    assign lvl_o = s2_q;

    generate
        if (DETECT_RISE) begin : g_rise
            assign edge_o = arm_q[ARM_STAGES-1] & s2_q & ~prev_q;
        end else begin : g_fall
            assign edge_o = arm_q[ARM_STAGES-1] & ~s2_q & prev_q;
        end
    endgenerate

    // R6: an edge report always matches the current synchronised level.
    a_r6_edge_level: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> (lvl_o == DETECT_RISE));
endmodule

// File: rtl/os_trig_decode.sv
`timescale 1ns/1ps
// Combines the synchronised levels and edges into one trigger strobe.
// Assumes: all inputs come from os_sync_edge instances in the same clock domain.
module os_trig_decode (
    input  logic a_lvl_i,
    input  logic a_fall_i,
    input  logic b_lvl_i,
    input  logic b_rise_i,
    input  logic c_lvl_i,
    input  logic c_rise_i,
    output logic trig_o
);
    logic via_b, via_a, via_c;

    // Each trigger path is gated by the level of the other input (inhibit).
    always_comb begin
        via_b  = b_rise_i & ~a_lvl_i;
        via_a  = a_fall_i &  b_lvl_i;
        via_c  = c_rise_i & ~a_lvl_i & b_lvl_i;
        trig_o = c_lvl_i & (via_b | via_a | via_c);
    end
endmodule

// File: rtl/os_pulse_timer.sv
`timescale 1ns/1ps
// Pulse generator for one channel: a fixed hold phase, then a run phase of
// the sampled width. A trigger in the hold phase is ignored. A trigger in the
// run phase restarts the run phase.
// Assumes: HOLD_CYC >= 1; trig_i and clr_lvl_i are synchronous.
module os_pulse_timer
    import os_pkg::*;
#(
    parameter int WIDTH_W  = 8,
    parameter int HOLD_CYC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_lvl_i,
    input  logic               trig_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               pulse_o
);
    localparam int HCW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_CYC - 1);

    phase_t             ph_q;
    logic [HCW-1:0]     hcnt_q;
    logic [WIDTH_W-1:0] tcnt_q, wlat_q, w_eff;

    // A width of zero is treated as one cycle.
    always_comb w_eff = (width_i == '0) ? WIDTH_W'(1) : width_i;

    // Phase sequencing with hold-phase and run-phase counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_lvl_i) begin
            ph_q   <= PH_IDLE;
            hcnt_q <= '0;
            tcnt_q <= '0;
            wlat_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (trig_i) begin
                        ph_q   <= PH_HOLD;
                        hcnt_q <= '0;
                        wlat_q <= w_eff;
                    end
                end
                PH_HOLD: begin
                    if (hcnt_q == HOLD_LAST) begin
                        ph_q   <= PH_RUN;
                        tcnt_q <= '0;
                    end else begin
                        hcnt_q <= hcnt_q + 1'b1;
                    end
                end
                PH_RUN: begin
                    if (trig_i) begin
                        tcnt_q <= '0;
                        wlat_q <= w_eff;
                    end else if (tcnt_q == wlat_q - 1'b1) begin
                        ph_q   <= PH_IDLE;
                        tcnt_q <= '0;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign pulse_o = (ph_q != PH_IDLE);

    // R4: a low clear level drops the pulse on the next edge.
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_lvl_i |=> !pulse_o);
    // R6: the pulse never rises without a trigger.
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_o && !trig_i) |=> !pulse_o);
    // R6: an accepted trigger always gives a high pulse.
    a_r6_trig_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && clr_lvl_i) |=> pulse_o);
    // R8: the hold phase always leads into the run phase, never to idle.
    a_r8_hold_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_HOLD && clr_lvl_i) |=> (ph_q != PH_IDLE));
    // R7: the run counter stays below the latched width.
    a_r7_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_RUN) |-> (tcnt_q < wlat_q));
endmodule

// File: rtl/os_dual_oneshot.sv
`timescale 1ns/1ps
// Multi-channel retriggerable one-shot. Each channel synchronises its three
// inputs, decodes the trigger conditions and runs its own pulse timer.
// Assumes: the inputs are asynchronous to clk; width_i is stable near triggers.
module os_dual_oneshot #(
    parameter int N_CH     = 2,
    parameter int WIDTH_W  = 8,
    parameter int HOLD_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CH-1:0]         fall_trig_i,
    input  logic [N_CH-1:0]         rise_trig_i,
    input  logic [N_CH-1:0]         clr_n_i,
    input  logic [N_CH*WIDTH_W-1:0] width_i,
    output logic [N_CH-1:0]         pulse_o,
    output logic [N_CH-1:0]         pulse_n_o
);
    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_ch
            logic a_lvl, a_fall, b_lvl, b_rise, c_lvl, c_rise, trig;

            os_sync_edge #(.DETECT_RISE(1'b0)) u_sync_a (
                .clk(clk), .rst_n(rst_n), .async_i(fall_trig_i[c]),
                .lvl_o(a_lvl), .edge_o(a_fall));
            os_sync_edge #(.DETECT_RISE(1'b1)) u_sync_b (
                .clk(clk), .rst_n(rst_n), .async_i(rise_trig_i[c]),
                .lvl_o(b_lvl), .edge_o(b_rise));
            os_sync_edge #(.DETECT_RISE(1'b1)) u_sync_c (
                .clk(clk), .rst_n(rst_n), .async_i(clr_n_i[c]),
                .lvl_o(c_lvl), .edge_o(c_rise));

            os_trig_decode u_dec (
                .a_lvl_i(a_lvl), .a_fall_i(a_fall),
                .b_lvl_i(b_lvl), .b_rise_i(b_rise),
                .c_lvl_i(c_lvl), .c_rise_i(c_rise),
                .trig_o(trig));

            os_pulse_timer #(.WIDTH_W(WIDTH_W), .HOLD_CYC(HOLD_CYC)) u_tmr (
                .clk(clk), .rst_n(rst_n), .clr_lvl_i(c_lvl), .trig_i(trig),
                .width_i(width_i[c*WIDTH_W +: WIDTH_W]),
                .pulse_o(pulse_o[c]));

            // R10: the inverse output follows the pulse.
            assign pulse_n_o[c] = ~pulse_o[c];
        end
    endgenerate
endmodule

// File: tb/os_dual_oneshot_bench.sv
`timescale 1ns/1ps
module os_dual_oneshot_bench;
    localparam int N_CH = 2, WW = 4, HOLD = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N_CH-1:0]    fa = '0, rb = '0, cl = '1;
    logic [N_CH*WW-1:0] wd = '0;
    logic [N_CH-1:0]    q, qn;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    os_dual_oneshot #(.N_CH(N_CH), .WIDTH_W(WW), .HOLD_CYC(HOLD)) u_os_dual_oneshot (
        .clk(clk), .rst_n(rst_n), .fall_trig_i(fa), .rise_trig_i(rb),
        .clr_n_i(cl), .width_i(wd), .pulse_o(q), .pulse_n_o(qn));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Observe 40 cycles after a stimulus applied at this negedge.
    // rt > 0: a retrigger edge is driven on rise_trig_i[ch] rt cycles later.
    // clr_at > 0: clr_n_i[ch] goes low clr_at cycles later.
    task automatic watch(input int ch, input int rt, input int clr_at,
                         input int exp_len, input string tag);
        int first = 0, len = 0, other = 0, badc = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (q[ch]) begin
                if (first == 0) first = i;
                len++;
            end
            if (q[1-ch]) other++;
            if (qn !== ~q) badc++;
            if (rt > 0 && i == rt - 1) rb[ch] = 1'b0;
            if (rt > 0 && i == rt)     rb[ch] = 1'b1;
            if (clr_at > 0 && i == clr_at) cl[ch] = 1'b0;
        end
        chk(len == exp_len, {tag, " length"}, len, exp_len);
        if (exp_len > 0) chk(first == 3, {tag, " R6 latency"}, first, 3);
        chk(other == 0, {tag, " R9 other channel"}, other, 0);
        chk(badc == 0, {tag, " R10 complement"}, badc, 0);
    endtask

    initial begin
        #(20 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(4);
        chk(q == '0, "R10 reset pulse", int'(q), 0);
        chk(qn == '1, "R10 reset inverse", int'(qn), 3);
        rst_n = 1'b1;
        idle(6);

        // R1 and R6: rising-edge trigger on channel 0, every width value.
        for (int w = 0; w < 16; w++) begin
            wd[0 +: WW] = WW'(w);
            rb[0] = 1'b1;
            watch(0, 0, 0, HOLD + ((w == 0) ? 1 : w), $sformatf("R1 w=%0d", w));
            rb[0] = 1'b0;
            idle(4);
        end

        // R5: A high inhibits B; this also sets up the R2 sweep on channel 1.
        fa[1] = 1'b1; idle(4);
        rb[1] = 1'b1;
        watch(1, 0, 0, 0, "R5 A-high blocks B");
        // R2 and R6: falling-edge trigger on channel 1, every width value.
        for (int w = 0; w < 16; w++) begin
            wd[WW +: WW] = WW'(w);
            fa[1] = 1'b0;
            watch(1, 0, 0, HOLD + ((w == 0) ? 1 : w), $sformatf("R2 w=%0d", w));
            fa[1] = 1'b1;
            idle(4);
        end
        rb[1] = 1'b0; fa[1] = 1'b0; idle(4);

        // R5: B low inhibits the A falling edge.
        fa[0] = 1'b1; idle(4);
        fa[0] = 1'b0;
        watch(0, 0, 0, 0, "R5 B-low blocks A");

        // R4: trigger while clear is low is ignored; R3: clear release triggers.
        wd[0 +: WW] = WW'(6);
        cl[0] = 1'b0; idle(4);
        rb[0] = 1'b1;
        watch(0, 0, 0, 0, "R4 trigger under clear");
        cl[0] = 1'b1;
        watch(0, 0, 0, HOLD + 6, "R3 clear-rise trigger");
        rb[0] = 1'b0; idle(4);

        // R4: clear mid-pulse drops the pulse three clocks later.
        wd[0 +: WW] = WW'(12);
        rb[0] = 1'b1;
        watch(0, 0, 5, 5, "R4 clear mid-pulse");
        rb[0] = 1'b0; idle(4);
        cl[0] = 1'b1; idle(6);

        // R7 and R8: retrigger delay sweep with width 5.
        wd[0 +: WW] = WW'(5);
        for (int d = 2; d <= HOLD + 5; d++) begin
            rb[0] = 1'b1;
            if (d <= HOLD)
                watch(0, d, 0, HOLD + 5, $sformatf("R8 ignored d=%0d", d));
            else
                watch(0, d, 0, d + 5, $sformatf("R7 extend d=%0d", d));
            rb[0] = 1'b0;
            idle(4);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule